// File: doc/BRIEF.md
# Output Short-Circuit Retry Controller

One copy of this controller sits beside each audio output channel. The output stage raises a detect line when it sees too much current, and the controller applies a retry policy to it. It switches the channel off, waits a fixed number of millisecond ticks and switches it back on. After power returns, it watches the channel for a second fixed span. Detections that follow one another through these spans are counted. When the count reaches the strike limit, the controller sets a short-circuit flag and a high-impedance flag and keeps the channel off.

A detection ends the observation span early. If the span runs out with no detection, the count falls back to zero. The flags stay set until the control logic sends a clear strobe, which it does when software writes the channel control register. Current sensing and the millisecond time base are outside this block. The wait span, the observation span, the strike limit and the detect qualification length are all parameters.

Top module: `scr_retry_ctrl`

## Requirements
- R1: While reset is held and after it is released, `pwr_en` is 1, `sc_flag` is 0, `hiz_flag` is 0 and the strike count is 0.
- R2: A qualified detection while `pwr_en` is 1 drives `pwr_en` to 0 at the next clock edge and adds one to the strike count.
- R3: When the strike count after a detection is below STRIKES, `pwr_en` stays 0 for WAIT_TICKS pulses of `tick_ms`. It returns to 1 at the clock edge that samples the last of those pulses.
- R4: Each power-on after a retry opens an observation span of WINDOW_TICKS pulses of `tick_ms`. A detection inside the span adds to the count. If the span expires with no detection, the count returns to 0 and the channel stays on.
- R5: The detection that brings the count to STRIKES sets `sc_flag` and `hiz_flag` to 1 and `pwr_en` to 0. All three then hold, whatever `tick_ms` does, until a clear strobe arrives.
- R6: A one-cycle `flag_clr` pulse sets `sc_flag` and `hiz_flag` to 0, the count to 0 and `pwr_en` to 1 at the next edge, and it closes any observation span. Nothing else clears the flags.
- R7: The detect input has no effect while `pwr_en` is 0, whether the channel is waiting to retry or locked in high impedance. The count is left unchanged.
- R8: `det_raw` passes through SYNC_STAGES flip-flops. It is a detection only after the synchronised level has been high for MIN_HIGH consecutive cycles while the channel is powered. With the defaults (2 and 2), a 1-cycle pulse is ignored. A pulse of 2 or more cycles turns `pwr_en` off at the fourth rising edge after `det_raw` first goes high.
- R9: When `flag_clr` and a qualified detection fall in the same cycle, the clear takes effect and the detection is dropped. It adds nothing to the count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| det_raw | input | 1 | Asynchronous short-circuit detect from the output stage |
| tick_ms | input | 1 | One-cycle pulse once per millisecond |
| flag_clr | input | 1 | One-cycle clear strobe, sent on a write to the channel control register |
| pwr_en | output | 1 | Channel power-on enable |
| sc_flag | output | 1 | Latched short-circuit flag |
| hiz_flag | output | 1 | Output stage held in high impedance |

## Verification
The strike count cannot be seen at the ports, so the hardest cases are the ones where only the count differs. These are the expiry of the observation span, detections that arrive while the channel is off, and a clear strobe that collides with a detection. The stimulus reaches each case by building up a known count and then applying the event in question. It then sends a measured number of further detections and checks whether the lock comes one detection early, on time or one detection late. For the collision, the bench times `flag_clr` to land in the single cycle in which the qualified detection is present, three edges after the detect pulse starts.

// File: rtl/scr_pkg.sv
package scr_pkg;

    typedef enum logic [1:0] {
        CH_LIVE   = 2'd0,
        CH_REST   = 2'd1,
        CH_LOCKED = 2'd2
    } ch_state_e;

    typedef struct packed {
        ch_state_e st;
        logic      win_open;
        logic      sc;
    } ch_ctl_s;

    function automatic int unsigned max2(input int unsigned a, input int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/scr_det_qual.sv
module scr_det_qual #(
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned MIN_HIGH    = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic en,
    input  logic det_raw,
    output logic det_evt
);
    localparam int unsigned CW = $clog2(MIN_HIGH + 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   level;
    logic [CW-1:0]          run_cnt;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= det_raw;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], det_raw};
            end
        end
    endgenerate

    assign level = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst || !en || !level)
            run_cnt <= '0;
        else if (run_cnt < CW'(MIN_HIGH - 1))
            run_cnt <= run_cnt + 1'b1;
    end

    assign det_evt = en && level && (run_cnt == CW'(MIN_HIGH - 1));

    // R8: a qualified detection needs the synchronised level high in the prior cycle too
    p_needs_history_r8: assert property (@(posedge clk) disable iff (rst)
        (det_evt && MIN_HIGH > 1) |-> $past(level));

    // R7: the qualifier count is empty in the cycle after the channel was off
    p_off_flushes_r7: assert property (@(posedge clk) disable iff (rst)
        !en |=> (run_cnt == '0));

endmodule

// File: rtl/scr_tick_timer.sv
module scr_tick_timer #(
    parameter int unsigned W = 6
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         restart,
    input  logic         run,
    input  logic         tick,
    input  logic [W-1:0] limit,
    output logic         done
);
    logic [W-1:0] cnt;

    assign done = run && tick && (cnt == limit - 1'b1);

    always_ff @(posedge clk) begin
        if (rst || restart)
            cnt <= '0;
        else if (run && tick)
            cnt <= done ? '0 : cnt + 1'b1;
    end

    // R3: the tick count never passes the programmed span
    p_cnt_bound_r3: assert property (@(posedge clk) disable iff (rst)
        (limit != '0) |-> (cnt < limit));

endmodule

// File: rtl/scr_retry_ctrl.sv
module scr_retry_ctrl
    import scr_pkg::*;
#(
    parameter int unsigned WAIT_TICKS   = 40,
    parameter int unsigned WINDOW_TICKS = 40,
    parameter int unsigned STRIKES      = 3,
    parameter int unsigned SYNC_STAGES  = 2,
    parameter int unsigned MIN_HIGH     = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic det_raw,
    input  logic tick_ms,
    input  logic flag_clr,
    output logic pwr_en,
    output logic sc_flag,
    output logic hiz_flag
);
    localparam int unsigned TW = $clog2(max2(WAIT_TICKS, WINDOW_TICKS) + 1);
    localparam int unsigned SW = $clog2(STRIKES + 1);

    ch_ctl_s       ctl_q, ctl_n;
    logic [SW-1:0] strikes_q, strikes_n;
    logic          det_evt;
    logic          tmr_restart, tmr_run, tmr_done;
    logic [TW-1:0] tmr_limit;

    scr_det_qual #(
        .SYNC_STAGES (SYNC_STAGES),
        .MIN_HIGH    (MIN_HIGH)
    ) u_qual (
        .clk     (clk),
        .rst     (rst),
        .en      (pwr_en),
        .det_raw (det_raw),
        .det_evt (det_evt)
    );

    assign tmr_limit = (ctl_q.st == CH_REST) ? TW'(WAIT_TICKS) : TW'(WINDOW_TICKS);
    assign tmr_run   = (ctl_q.st == CH_REST) || (ctl_q.st == CH_LIVE && ctl_q.win_open);

    scr_tick_timer #(.W(TW)) u_timer (
        .clk     (clk),
        .rst     (rst),
        .restart (tmr_restart),
        .run     (tmr_run),
        .tick    (tick_ms),
        .limit   (tmr_limit),
        .done    (tmr_done)
    );

    always_comb begin
        ctl_n       = ctl_q;
        strikes_n   = strikes_q;
        tmr_restart = 1'b0;
        if (flag_clr) begin
            ctl_n       = '{st: CH_LIVE, win_open: 1'b0, sc: 1'b0};
            strikes_n   = '0;
            tmr_restart = 1'b1;
        end else begin
            unique case (ctl_q.st)
                CH_LIVE: begin
                    if (det_evt) begin
                        strikes_n      = strikes_q + 1'b1;
                        ctl_n.win_open = 1'b0;
                        tmr_restart    = 1'b1;
                        if (strikes_n == SW'(STRIKES)) begin
                            ctl_n.st = CH_LOCKED;
                            ctl_n.sc = 1'b1;
                        end else begin
                            ctl_n.st = CH_REST;
                        end
                    end else if (ctl_q.win_open && tmr_done) begin
                        ctl_n.win_open = 1'b0;
                        strikes_n      = '0;
                        tmr_restart    = 1'b1;
                    end
                end
                CH_REST: begin
                    if (tmr_done) begin
                        ctl_n.st       = CH_LIVE;
                        ctl_n.win_open = 1'b1;
                        tmr_restart    = 1'b1;
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q     <= '{st: CH_LIVE, win_open: 1'b0, sc: 1'b0};
            strikes_q <= '0;
        end else begin
            ctl_q     <= ctl_n;
            strikes_q <= strikes_n;
        end
    end

    assign pwr_en   = (ctl_q.st == CH_LIVE);
    assign hiz_flag = (ctl_q.st == CH_LOCKED);
    assign sc_flag  = ctl_q.sc;

    // R5: the short-circuit flag and the high-impedance state always agree
    p_flags_agree_r5: assert property (@(posedge clk) disable iff (rst)
        sc_flag == hiz_flag);

    // R5: the locked state holds until a clear strobe
    p_locked_holds_r5: assert property (@(posedge clk) disable iff (rst)
        (hiz_flag && !flag_clr) |=> (hiz_flag && sc_flag && !pwr_en));

    // R6: a clear strobe restores normal operation at the next edge
    p_clear_restores_r6: assert property (@(posedge clk) disable iff (rst)
        flag_clr |=> (pwr_en && !sc_flag && !hiz_flag));

    // R2: a qualified detection without a clear turns the channel off
    p_detect_drops_power_r2: assert property (@(posedge clk) disable iff (rst)
        (det_evt && !flag_clr) |=> !pwr_en);

    // R3: outside a clear, power only returns on a tick
    p_retry_on_tick_r3: assert property (@(posedge clk) disable iff (rst)
        ($rose(pwr_en) && !$past(flag_clr)) |-> $past(tick_ms));

    // R4: the strike count never passes the limit
    p_strikes_bound_r4: assert property (@(posedge clk) disable iff (rst)
        strikes_q <= SW'(STRIKES));

endmodule

// File: tb/scr_retry_ctrl_test.sv
`timescale 1ns/1ps
module scr_retry_ctrl_test;
    localparam int CLK_PERIOD = 10;
    localparam int WAIT_T     = 40;
    localparam int WIN_T      = 40;
    localparam int WATCHDOG   = 50000;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic det_raw = 1'b0;
    logic tick_ms = 1'b0;
    logic flag_clr = 1'b0;
    logic pwr_en, sc_flag, hiz_flag;

    int n_checks = 0;
    int n_fail   = 0;
    bit done_run = 1'b0;

    typedef struct {
        logic  pwr;
        logic  sc;
        logic  hiz;
        string req;
    } exp_t;

    exp_t exp_q[$];
    event chk_ev;

    always #(CLK_PERIOD/2) clk = ~clk;

    scr_retry_ctrl uut (
        .clk      (clk),
        .rst      (rst),
        .det_raw  (det_raw),
        .tick_ms  (tick_ms),
        .flag_clr (flag_clr),
        .pwr_en   (pwr_en),
        .sc_flag  (sc_flag),
        .hiz_flag (hiz_flag)
    );

    // monitor: pops expected items and compares them with the outputs
    initial begin
        forever begin
            @(chk_ev);
            #1;
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                n_checks++;
                if ({pwr_en, sc_flag, hiz_flag} !== {e.pwr, e.sc, e.hiz}) begin
                    n_fail++;
                    $display("FAIL %s: pwr/sc/hiz actual %b%b%b expected %b%b%b",
                             e.req, pwr_en, sc_flag, hiz_flag, e.pwr, e.sc, e.hiz);
                end
            end
        end
    end

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_out(input logic p, input logic s, input logic h, input string req);
        exp_t e;
        e.pwr = p; e.sc = s; e.hiz = h; e.req = req;
        exp_q.push_back(e);
        -> chk_ev;
        wait (exp_q.size() == 0);
    endtask

    task automatic ticks(input int n);
        repeat (n) begin
            tick_ms = 1'b1;
            step(1);
            tick_ms = 1'b0;
            step(1);
        end
    endtask

    // two-cycle detect pulse; returns once the channel should be off
    task automatic detect();
        det_raw = 1'b1;
        step(2);
        det_raw = 1'b0;
        step(2);
    endtask

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        expect_out(1, 0, 0, "R1 reset state");

        // R8: a single-cycle pulse is filtered out
        det_raw = 1'b1; step(1); det_raw = 1'b0; step(6);
        expect_out(1, 0, 0, "R8 one-cycle pulse ignored");

        // R8 latency then R2 power-off (strike 1)
        det_raw = 1'b1; step(2); det_raw = 1'b0; step(1);
        expect_out(1, 0, 0, "R8 not yet qualified after three edges");
        step(1);
        expect_out(0, 0, 0, "R2 power off on detection");

        // R3: wait span boundary
        ticks(WAIT_T - 1);
        expect_out(0, 0, 0, "R3 still off one tick early");
        ticks(1);
        expect_out(1, 0, 0, "R3 power on after wait span");

        // R4: detection inside the span (strike 2)
        ticks(5);
        detect();
        expect_out(0, 0, 0, "R4 in-span detection powers off");
        ticks(WAIT_T);
        expect_out(1, 0, 0, "R3 second retry powers on");

        // R4: let the span expire, count returns to 0
        ticks(WIN_T);
        expect_out(1, 0, 0, "R4 span expiry keeps channel on");
        detect();
        expect_out(0, 0, 0, "R4 count reset so no lock (strike 1)");
        ticks(WAIT_T);
        detect();
        expect_out(0, 0, 0, "R4 strike 2 not locked");
        ticks(WAIT_T);
        detect();
        expect_out(0, 1, 1, "R5 third consecutive detection locks");

        // R5/R7: lock holds through ticks and detects
        ticks(WAIT_T + WIN_T);
        det_raw = 1'b1; step(8); det_raw = 1'b0; step(2);
        expect_out(0, 1, 1, "R5 R7 lock holds, detect ignored");

        // R6: clear
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        expect_out(1, 0, 0, "R6 clear restores operation");

        // R7: detection during the wait span is ignored
        detect();
        expect_out(0, 0, 0, "R7 strike 1");
        det_raw = 1'b1; step(10); det_raw = 1'b0; step(4);
        ticks(WAIT_T);
        expect_out(1, 0, 0, "R7 retry not disturbed by detect while off");
        detect();
        expect_out(0, 0, 0, "R7 only strike 2 after ignored detect");
        ticks(WAIT_T);
        expect_out(1, 0, 0, "R7 back on with count 2");

        // R9: clear collides with a qualified detection
        det_raw = 1'b1; step(2); det_raw = 1'b0; step(1);
        flag_clr = 1'b1; step(1); flag_clr = 1'b0;
        expect_out(1, 0, 0, "R9 clear wins over detection");
        step(4);
        expect_out(1, 0, 0, "R9 channel stays on after collision");
        detect();
        ticks(WAIT_T);
        detect();
        expect_out(0, 0, 0, "R9 count restarted, strike 2 not locked");
        ticks(WAIT_T);
        detect();
        expect_out(0, 1, 1, "R9 R5 lock on third strike after clear");

        done_run = 1'b1;
    end

    initial begin
        int cyc;
        cyc = 0;
        while (!done_run && cyc < WATCHDOG) begin
            @(posedge clk);
            cyc++;
        end
        if (!done_run) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout after %0d cycles, expected completion", cyc);
        end
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule